// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It decodes a small load/store instruction set: five register-to-register operations (add, subtract, bitwise and, bitwise or, signed set-less-than), or with an immediate, load word, store word, branch when two registers are equal, and an absolute jump. Inside the core are a program counter with its next-address logic, a 32-entry register file with two read ports and one write port, an immediate extender that can zero-extend or sign-extend, an ALU, and the selectors that choose the ALU operand and the write-back value.

Both memories are outside the core and are ideal: reads are combinational. The core presents the current program counter as the instruction address and receives the instruction word in the same cycle. For data, it drives an address, write data and a write strobe, and the read word comes back in the same cycle. The decoder produces a small set of steering bits: destination select, operand-B select, extension mode, write-back select, register write, memory write, branch and jump. Register writes, memory writes and the program counter update all take effect on the rising clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. No register is written. Asserting `rst_n` low returns the program counter to 0 at once.
- R2: Any instruction other than a taken branch or a jump sets the next instruction address to the current address plus 4.
- R3: When opcode bits [31:26] are 000000, the instruction is register-type. funct bits [5:0] select the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 and, 0x25 or, 0x2A signed less-than giving 1 or 0. The result is written to rd, bits [15:11]. rs is bits [25:21] and rt is bits [20:16].
- R4: Opcode 0x0D writes rs OR the zero-extended bits [15:0] into rt.
- R5: Opcode 0x23 reads data memory at rs plus the sign-extended bits [15:0] and writes the word read into rt.
- R6: Opcode 0x2B asserts `dmem_we` for one cycle, with `dmem_addr` set to rs plus the sign-extended immediate and `dmem_wdata` set to rt. No register is written.
- R7: Opcode 0x04 compares rs with rt. If they are equal, the next address is the current address + 4 + (sign-extended immediate × 4). Otherwise the next address is the current address + 4. No register or memory write occurs.
- R8: Opcode 0x02 sets the next address to {bits [31:28] of current address + 4, bits [25:0], 2'b00}.
- R9: Register 0 always reads as zero, and any write addressed to it is discarded.
- R10: An opcode outside the six listed above writes no register and no memory location, and advances the address by 4.
- R11: A register-type instruction whose funct is not one of the five listed writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (value of register rt) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 32 | Data memory word at `dmem_addr` |

## Verification
The register file has no port of its own, so its contents can only be observed through store instructions. Each directed program therefore ends by storing the registers of interest, and the bench compares the resulting data-memory words with values it works out by hand. The hardest cases to reach are writes that must be discarded: writes to register 0, and register writes attempted by stores, unknown opcodes and unlisted funct codes. To expose them, each of those instructions names a destination register that already holds a known value. A later store then shows whether that value survived. Branch and jump targets are checked by tracing the instruction address cycle by cycle, including a backward branch onto itself.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NREG   = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JMP   = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;    // destination is rd (else rt)
    logic    opb_imm;   // ALU B is extended immediate (else rt value)
    logic    ext_sign;  // sign-extend immediate (else zero-extend)
    logic    wb_mem;    // write back memory word (else ALU result)
    logic    rf_we;     // register file write
    logic    dm_we;     // data memory write
    logic    is_beq;    // conditional branch
    logic    is_jmp;    // absolute jump
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ext16(input logic [15:0] imm, input logic sgn);
    return {{(DATA_W-16){sgn & imm[15]}}, imm};
  endfunction

  function automatic logic [DATA_W-1:0] alu_calc(input alu_op_e op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (op)
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = ($signed(a) < $signed(b)) ? DATA_W'(1) : '0;
      default: r = a + b;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] branch_tgt(input logic [DATA_W-1:0] pc4,
                                                   input logic [15:0] off);
    return pc4 + {{(DATA_W-18){off[15]}}, off, 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] jump_tgt(input logic [DATA_W-1:0] pc4,
                                                 input logic [25:0] idx);
    return {pc4[DATA_W-1:28], idx, 2'b00};
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  // main decode
  ctrl_t   main_c;
  alu_op_e rtype_op;
  logic    rtype_ok;

  always_comb begin
    main_c        = '0;
    main_c.alu_op = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin main_c.dst_rd = 1'b1; main_c.rf_we = 1'b1; end
      OPC_ORI:   begin main_c.opb_imm = 1'b1; main_c.rf_we = 1'b1; main_c.alu_op = ALU_OR; end
      OPC_LW:    begin main_c.opb_imm = 1'b1; main_c.ext_sign = 1'b1;
                       main_c.wb_mem = 1'b1; main_c.rf_we = 1'b1; end
      OPC_SW:    begin main_c.opb_imm = 1'b1; main_c.ext_sign = 1'b1; main_c.dm_we = 1'b1; end
      OPC_BEQ:   begin main_c.is_beq = 1'b1; main_c.alu_op = ALU_SUB; end
      OPC_JMP:   main_c.is_jmp = 1'b1;
      default:   ;
    endcase
  end

  // local ALU decode of the funct field
  always_comb begin
    rtype_ok = 1'b1;
    rtype_op = ALU_ADD;
    case (funct)
      FN_ADD:  rtype_op = ALU_ADD;
      FN_SUB:  rtype_op = ALU_SUB;
      FN_AND:  rtype_op = ALU_AND;
      FN_OR:   rtype_op = ALU_OR;
      FN_SLT:  rtype_op = ALU_SLT;
      default: rtype_ok = 1'b0;
    endcase
  end

  always_comb begin
    ctrl = main_c;
    if (main_c.dst_rd) begin
      ctrl.alu_op = rtype_op;
      ctrl.rf_we  = rtype_ok;
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_fetch.sv
module sc_fetch
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_taken,
  input  logic              jmp_taken,
  input  logic [15:0]       br_off,
  input  logic [25:0]       jmp_idx,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] pc_seq
);
  logic [DATA_W-1:0] pc_nxt;

  assign pc_seq = pc + DATA_W'(4);

  always_comb begin
    if (jmp_taken)     pc_nxt = jump_tgt(pc_seq, jmp_idx);
    else if (br_taken) pc_nxt = branch_tgt(pc_seq, br_off);
    else               pc_nxt = pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int unsigned RAW = $clog2(NREG);

  // instruction fields
  logic [5:0]     opcode, funct;
  logic [RAW-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic [15:0]    imm16;
  logic [25:0]    jmp_idx;
  logic           unused_shamt;

  assign opcode       = imem_rdata[31:26];
  assign rs_idx       = imem_rdata[25:21];
  assign rt_idx       = imem_rdata[20:16];
  assign rd_idx       = imem_rdata[15:11];
  assign funct        = imem_rdata[5:0];
  assign imm16        = imem_rdata[15:0];
  assign jmp_idx      = imem_rdata[25:0];
  assign unused_shamt = ^imem_rdata[10:6];

  // named internal events for the checker
  ctrl_t             ctrl;
  logic [DATA_W-1:0] rs_val, rt_val, imm_ext, opb, alu_res, wb_val, pc_seq;
  logic              br_taken, jmp_taken, rf_wr_req;

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;
  assign imm_ext = ext16(imm16, ctrl.ext_sign);
  assign opb     = ctrl.opb_imm ? imm_ext : rt_val;
  assign alu_res = alu_calc(ctrl.alu_op, rs_val, opb);
  assign wb_val  = ctrl.wb_mem ? dmem_rdata : alu_res;

  assign br_taken  = ctrl.is_beq & (alu_res == '0);
  assign jmp_taken = ctrl.is_jmp;
  assign rf_wr_req = ctrl.rf_we & rst_n;

  sc_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_wr_req),
    .waddr   (dst_idx),
    .wdata   (wb_val),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  sc_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_taken  (br_taken),
    .jmp_taken (jmp_taken),
    .br_off    (imm16),
    .jmp_idx   (jmp_idx),
    .pc        (imem_addr),
    .pc_seq    (pc_seq)
  );

  assign dmem_addr  = alu_res;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.dm_we & rst_n;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic        rf_wr_req,
  input logic        br_taken,
  input logic        jmp_taken,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (imem_addr == 32'd0 && !dmem_we)); // R1

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_taken && !jmp_taken) |=> imem_addr == $past(imem_addr) + 32'd4); // R2

  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> imem_addr == $past(imem_addr) + 32'd4 +
      {{14{$past(imem_rdata[15])}}, $past(imem_rdata[15:0]), 2'b00}); // R7

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_taken |=> imem_addr[27:0] == {$past(imem_rdata[25:0]), 2'b00}); // R8

  AST_R0_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == 5'd0) |-> (rs_val == 32'd0)); // R9

  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !rf_wr_req); // R6
endmodule

bind sc_core sc_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .rf_wr_req  (rf_wr_req),
  .br_taken   (br_taken),
  .jmp_taken  (jmp_taken),
  .rs_idx     (rs_idx),
  .rs_val     (rs_val)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sc_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // encoders
  function automatic logic [31:0] r_op(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_op(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] j_op(input logic [25:0] idx);
    return {6'h02, idx};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_mem();
    imem[0] = i_op(6'h2B, 0, 0, 16'h0000);
    dmem[0] = 32'h5A5A5A5A;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 addr in reset", imem_addr, 32'd0);
    chk("R1 we in reset", {31'd0, dmem_we}, 32'd0);
    chk("R1 mem untouched", dmem[0], 32'h5A5A5A5A);
    rst_n = 1'b1;
    run(3);
    rst_n = 1'b0; #1;
    chk("R1 async return to 0", imem_addr, 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_alu();
    clear_mem();
    imem[0]  = i_op(6'h0D, 0, 1, 16'h8005);
    imem[1]  = i_op(6'h0D, 0, 2, 16'h0003);
    imem[2]  = r_op(1, 2, 3, 6'h20);
    imem[3]  = r_op(2, 1, 4, 6'h22);
    imem[4]  = r_op(1, 2, 5, 6'h24);
    imem[5]  = r_op(1, 2, 6, 6'h25);
    imem[6]  = r_op(4, 2, 7, 6'h2A);
    imem[7]  = r_op(2, 4, 8, 6'h2A);
    imem[8]  = i_op(6'h2B, 0, 3, 16'd0);
    imem[9]  = i_op(6'h2B, 0, 4, 16'd4);
    imem[10] = i_op(6'h2B, 0, 5, 16'd8);
    imem[11] = i_op(6'h2B, 0, 6, 16'd12);
    imem[12] = i_op(6'h2B, 0, 7, 16'd16);
    imem[13] = i_op(6'h2B, 0, 8, 16'd20);
    imem[14] = i_op(6'h2B, 0, 1, 16'd24);
    do_reset();
    run(15);
    chk("R3 add", dmem[0], 32'h00008008);
    chk("R3 sub", dmem[1], 32'hFFFF7FFE);
    chk("R3 and", dmem[2], 32'h00000001);
    chk("R3 or", dmem[3], 32'h00008007);
    chk("R3 slt neg<pos", dmem[4], 32'h00000001);
    chk("R3 slt pos<neg", dmem[5], 32'h00000000);
    chk("R4 ori zero-ext", dmem[6], 32'h00008005);
  endtask

  task automatic t_mem();
    clear_mem();
    dmem[9]  = 32'h12345678;
    dmem[10] = 32'hCAFEF00D;
    dmem[2]  = 32'hFFFFFFFF;
    imem[0]  = i_op(6'h0D, 0, 1, 16'd48);
    imem[1]  = i_op(6'h23, 1, 2, 16'hFFF8);
    imem[2]  = i_op(6'h23, 1, 3, 16'hFFF4);
    imem[3]  = r_op(2, 3, 0, 6'h20);
    imem[4]  = i_op(6'h0D, 0, 0, 16'h0007);
    imem[5]  = i_op(6'h2B, 0, 2, 16'd0);
    imem[6]  = i_op(6'h2B, 1, 3, 16'd4);
    imem[7]  = i_op(6'h2B, 0, 0, 16'd8);
    imem[8]  = i_op(6'h0D, 0, 5, 16'h0077);
    imem[9]  = i_op(6'h2B, 0, 5, 16'd60);
    imem[10] = i_op(6'h2B, 0, 5, 16'd56);
    do_reset();
    run(11);
    chk("R5 load neg offset", dmem[0], 32'hCAFEF00D);
    chk("R5 load then R6 store offset", dmem[13], 32'h12345678);
    chk("R9 r0 stays zero", dmem[2], 32'h00000000);
    chk("R6 store data", dmem[15], 32'h00000077);
    chk("R6 store leaves rt", dmem[14], 32'h00000077);
  endtask

  task automatic t_flow();
    clear_mem();
    imem[0]  = i_op(6'h0D, 0, 1, 16'd5);
    imem[1]  = i_op(6'h0D, 0, 2, 16'd5);
    imem[2]  = i_op(6'h0D, 0, 3, 16'd6);
    imem[3]  = i_op(6'h04, 1, 3, 16'd5);
    imem[4]  = i_op(6'h04, 1, 2, 16'd2);
    imem[5]  = i_op(6'h0D, 0, 9, 16'h0BAD);
    imem[6]  = i_op(6'h0D, 0, 9, 16'h0BAD);
    imem[7]  = j_op(26'd10);
    imem[8]  = i_op(6'h2B, 0, 0, 16'd0);
    imem[10] = i_op(6'h0D, 0, 11, 16'd1);
    imem[11] = i_op(6'h04, 0, 0, 16'hFFFF);
    dmem[0]  = 32'h600D600D;
    do_reset();
    chk("R2 start", imem_addr, 32'd0);
    run(1); chk("R2 seq", imem_addr, 32'd4);
    run(1); chk("R2 seq", imem_addr, 32'd8);
    run(1); chk("R2 seq", imem_addr, 32'd12);
    run(1); chk("R7 not taken", imem_addr, 32'd16);
    run(1); chk("R7 taken fwd", imem_addr, 32'd28);
    run(1); chk("R8 jump", imem_addr, 32'd40);
    run(1); chk("R2 after jump", imem_addr, 32'd44);
    run(1); chk("R7 taken backward", imem_addr, 32'd44);
    run(1); chk("R8 skipped store", dmem[0], 32'h600D600D);
  endtask

  task automatic t_illegal();
    clear_mem();
    dmem[0] = 32'h0000DEAD;
    imem[0] = i_op(6'h0D, 0, 1, 16'h0011);
    imem[1] = {6'h3F, 5'd0, 5'd1, 16'h0004};
    imem[2] = r_op(0, 0, 1, 6'h07);
    imem[3] = i_op(6'h2B, 0, 1, 16'd0);
    do_reset();
    run(1);
    chk("R10 unknown op no store", {31'd0, dmem_we}, 32'd0);
    run(1);
    chk("R10 unknown op advances", imem_addr, 32'd8);
    run(2);
    chk("R10 R11 r1 unchanged", dmem[0], 32'h00000011);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_flow();
    t_illegal();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule